// File: doc/BRIEF.md
# Lane Request Coalescer

This block sits between a group of 16 parallel lanes and the memory system. Each request carries one byte address per lane, an active bit per lane, a shared element-size code and a mode bit. The unit checks whether the active lanes together touch one aligned contiguous region. If they do, it sends a single burst that covers the region. If they do not, it sends one single-element transaction per active lane. The unit only describes read transactions. It returns no data and does not model memory timing.

The element-size code is 2 bits wide. Code 0 means 4 bytes, code 1 means 8 bytes and code 2 means 16 bytes. Code 3 marks a size the burst path does not support. A region is 16 elements long, so a burst is 64, 128 or 256 bytes. In strict mode, active lane k must address element k of an aligned region. In relaxed mode, the active lanes may address the elements of one aligned region in any order, as long as no two of them address the same element. Inactive lanes never affect the decision.

A state machine controls the unit. It has three states. ST_IDLE accepts a request. ST_BURST holds the single burst until the consumer takes it. ST_SERIAL emits the per-lane transactions one at a time. The transitions are:
- ST_IDLE to ST_BURST on a request that coalesces.
- ST_IDLE to ST_SERIAL on a request that does not coalesce.
- ST_IDLE to ST_IDLE on a request with no active lane.
- ST_BURST to ST_IDLE when the burst is taken.
- ST_SERIAL to ST_IDLE when the last pending lane is taken.

Top module: `mem_coalescer`

## Requirements
- R1: The byte length of an element is 4 for size code 0, 8 for code 1 and 16 for code 2. A burst's out_len is 16 times the element length (64, 128 or 256). A per-lane transaction's out_len is the element length.
- R2: In strict mode (in_relaxed=0), a request coalesces when every active lane k addresses base + k*element length and base is a multiple of the region length. The unit then emits exactly one transaction with out_burst=1, out_addr=base and out_lane=0.
- R3: In strict mode, a request whose implied base is not a multiple of the region length is serialized.
- R4: The address of an inactive lane has no effect. A request whose active lanes all follow the rules coalesces whatever its inactive lanes hold.
- R5: In relaxed mode (in_relaxed=1), a request coalesces when every active lane addresses a distinct element-aligned element inside the aligned region that holds the lowest active lane. out_addr is then that region's start. The same permuted request in strict mode is serialized.
- R6: In relaxed mode, two active lanes addressing the same element make the request serialize.
- R7: Size code 3 never coalesces. Each of its per-lane transactions carries out_len=0.
- R8: A serialized request emits one transaction per active lane, in ascending lane order. Each has out_burst=0, out_lane equal to the lane number and out_addr equal to that lane's address.
- R9: A request with no active lane emits nothing, and in_ready is high in the cycle after it is accepted.
- R10: in_ready is low whenever out_valid is high. While out_valid is high and out_ready is low, out_valid, out_addr, out_len and out_lane stay unchanged.
- R11: After reset, in_ready is 1 and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| in_addr | input | 512 | Lane byte addresses; lane k sits in bits [32k+31:32k] |
| in_mask | input | 16 | Active bit per lane; bit k belongs to lane k |
| in_size | input | 2 | Element-size code (0: 4 B, 1: 8 B, 2: 16 B, 3: unsupported) |
| in_relaxed | input | 1 | 1 selects relaxed rules, 0 selects strict rules |
| out_valid | output | 1 | Transaction valid |
| out_ready | input | 1 | Consumer takes the transaction when high together with out_valid |
| out_addr | output | 32 | Transaction start byte address |
| out_len | output | 9 | Transaction length in bytes |
| out_burst | output | 1 | 1 for a coalesced burst, 0 for a per-lane transaction |
| out_lane | output | 4 | Lane of a per-lane transaction, 0 for a burst |

## Verification
A request accepted at a clock edge makes its first transaction visible on the outputs right after that same edge. Each later transaction of a serialized request appears right after the edge that handed over the previous one. in_ready rises again one edge after the last transaction is taken. A request with no active lane leaves in_ready high in the very next cycle. The bench drives inputs and applies its back-pressure pattern on the falling edge. A driver task predicts the transaction list for every request and queues it. A falling-edge monitor compares each transaction that meets a high out_ready against the head of that queue. The monitor also compares held outputs across stalled cycles. This way, every comparison lines up with the edge at which the handshake actually happens.

// File: rtl/coal_pkg.sv
package coal_pkg;

    typedef enum logic [1:0] {
        SZ_W4  = 2'd0,
        SZ_W8  = 2'd1,
        SZ_W16 = 2'd2,
        SZ_BAD = 2'd3
    } esize_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BURST  = 2'd1,
        ST_SERIAL = 2'd2
    } coal_state_t;

    // log2 of the element byte length for a supported code
    function automatic logic [5:0] elem_shift(input logic [1:0] code);
        return 6'd2 + {4'd0, code};
    endfunction

endpackage

// File: rtl/coal_lane_pick.sv
module coal_lane_pick #(
    parameter int LANES  = 16,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [LANES-1:0]  mask,
    output logic              any,
    output logic [LANE_W-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int j = LANES - 1; j >= 0; j--) begin
            if (mask[j]) begin
                idx = LANE_W'(j);
            end
        end
        any = |mask;
    end

endmodule

// File: rtl/coal_rule_check.sv
module coal_rule_check
    import coal_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int AW     = 32,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [LANES*AW-1:0] addr_flat,
    input  logic [LANES-1:0]    mask,
    input  logic [1:0]          size,
    input  logic                relaxed,
    output logic                any,
    output logic                coalesce,
    output logic [AW-1:0]       base
);

    logic [LANE_W-1:0] lo_idx;
    logic [AW-1:0]     lo_addr;
    logic [5:0]        es_sh;
    logic [5:0]        rg_sh;
    logic [AW-1:0]     es_low;

    logic [LANES-1:0]  strict_ok;
    logic [LANES-1:0]  relax_ok;
    logic [LANES-1:0]  slot_oh [LANES];
    logic [LANES-1:0]  slot_all;
    logic              distinct;

    coal_lane_pick #(.LANES(LANES)) u_first (
        .mask (mask),
        .any  (any),
        .idx  (lo_idx)
    );

    always_comb begin
        es_sh   = elem_shift(size);
        rg_sh   = es_sh + 6'(LANE_W);
        es_low  = (AW'(1) << es_sh) - AW'(1);
        lo_addr = addr_flat[lo_idx*AW +: AW];
        base    = (lo_addr >> rg_sh) << rg_sh;
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [AW-1:0]     a_j;
        logic [LANE_W-1:0] slot_j;
        logic              in_reg_j;
        logic              aligned_j;

        always_comb begin
            a_j       = addr_flat[j*AW +: AW];
            slot_j    = LANE_W'(a_j >> es_sh);
            in_reg_j  = (a_j >> rg_sh) == (base >> rg_sh);
            aligned_j = (a_j & es_low) == '0;
            strict_ok[j] = !mask[j] || (a_j == (base + (AW'(j) << es_sh)));
            relax_ok[j]  = !mask[j] || (in_reg_j && aligned_j);
            slot_oh[j]   = mask[j] ? (LANES'(1) << slot_j) : '0;
        end
    end

    always_comb begin
        slot_all = '0;
        for (int j = 0; j < LANES; j++) begin
            slot_all = slot_all | slot_oh[j];
        end
        distinct = ($countones(slot_all) == $countones(mask));
        if (!any || size == SZ_BAD) begin
            coalesce = 1'b0;
        end else if (relaxed) begin
            coalesce = (&relax_ok) && distinct;
        end else begin
            coalesce = &strict_ok;
        end
    end

endmodule

// File: rtl/mem_coalescer.sv
module mem_coalescer
    import coal_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int AW     = 32,
    localparam int LANE_W = $clog2(LANES),
    localparam int LEN_W  = $clog2(LANES * 16) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [LANES*AW-1:0] in_addr,
    input  logic [LANES-1:0]    in_mask,
    input  logic [1:0]          in_size,
    input  logic                in_relaxed,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [AW-1:0]       out_addr,
    output logic [LEN_W-1:0]    out_len,
    output logic                out_burst,
    output logic [LANE_W-1:0]   out_lane
);

    coal_state_t        st, st_nx;
    logic [LANES*AW-1:0] addr_q;
    logic [LANES-1:0]    pend_q;
    logic [1:0]          size_q;
    logic [AW-1:0]       base_q;

    logic                chk_any;
    logic                chk_coal;
    logic [AW-1:0]       chk_base;
    logic                pend_any;
    logic [LANE_W-1:0]   pend_idx;
    logic [LANES-1:0]    pend_left;
    logic                take_in;
    logic                take_out;

    coal_rule_check #(.LANES(LANES), .AW(AW)) u_rules (
        .addr_flat (in_addr),
        .mask      (in_mask),
        .size      (in_size),
        .relaxed   (in_relaxed),
        .any       (chk_any),
        .coalesce  (chk_coal),
        .base      (chk_base)
    );

    coal_lane_pick #(.LANES(LANES)) u_next (
        .mask (pend_q),
        .any  (pend_any),
        .idx  (pend_idx)
    );

    assign take_in   = in_valid && in_ready;
    assign take_out  = out_valid && out_ready;
    assign pend_left = pend_q & ~(LANES'(1) << pend_idx);

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (take_in && chk_any) begin
                    st_nx = chk_coal ? ST_BURST : ST_SERIAL;
                end
            end
            ST_BURST: begin
                if (out_ready) st_nx = ST_IDLE;
            end
            ST_SERIAL: begin
                if (out_ready && (pend_left == '0 || !pend_any)) st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // request storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            pend_q <= '0;
            size_q <= '0;
            base_q <= '0;
        end else if (take_in) begin
            addr_q <= in_addr;
            pend_q <= in_mask;
            size_q <= in_size;
            base_q <= chk_base;
        end else if (st == ST_SERIAL && take_out) begin
            pend_q <= pend_left;
        end
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_addr  = '0;
        out_len   = '0;
        out_burst = 1'b0;
        out_lane  = '0;
        unique case (st)
            ST_IDLE: begin
                in_ready = 1'b1;
            end
            ST_BURST: begin
                out_valid = 1'b1;
                out_burst = 1'b1;
                out_addr  = base_q;
                out_len   = LEN_W'(LANES) << elem_shift(size_q);
            end
            ST_SERIAL: begin
                out_valid = 1'b1;
                out_lane  = pend_idx;
                out_addr  = addr_q[pend_idx*AW +: AW];
                out_len   = (size_q == SZ_BAD) ? '0 : (LEN_W'(1) << elem_shift(size_q));
            end
            default: ;
        endcase
    end

    p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_len) && $stable(out_lane));

    p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    p_burst_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_burst |-> ((out_addr & (AW'(out_len) - AW'(1))) == '0));

    p_burst_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_burst |-> (out_len >= LEN_W'(LANES * 4)) && ($countones(out_len) == 1));

    p_lane_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_burst && $past(out_valid && out_ready && !out_burst) |-> out_lane > $past(out_lane));

    p_empty_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_mask == '0 |=> in_ready && !out_valid);

endmodule

// File: tb/mem_coalescer_test.sv
`timescale 1ns/1ps
module mem_coalescer_test;

    localparam int L  = 16;
    localparam int AW = 32;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [8:0]    len;
        logic          burst;
        logic [3:0]    lane;
    } item_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [L*AW-1:0] in_addr = '0;
    logic [L-1:0]    in_mask = '0;
    logic [1:0]      in_size = '0;
    logic            in_relaxed = 1'b0;
    logic            out_valid;
    logic            out_ready = 1'b1;
    logic [AW-1:0]   out_addr;
    logic [8:0]      out_len;
    logic            out_burst;
    logic [3:0]      out_lane;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    item_t exp_q[$];
    string tag_q[$];
    logic [AW-1:0] a [L];

    always #2 clk = ~clk;

    mem_coalescer uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
        .in_mask(in_mask), .in_size(in_size), .in_relaxed(in_relaxed),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_len(out_len), .out_burst(out_burst), .out_lane(out_lane)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // bench-side prediction from the requirements
    task automatic predict(input logic [L-1:0] m, input logic [1:0] sz,
                           input logic rel, input string tag);
        int unsigned es, region, lo, off;
        logic [AW-1:0] base;
        logic [L-1:0] used;
        bit ok;
        item_t it;
        es = 4 << sz;
        region = L * es;
        lo = L;
        for (int j = L - 1; j >= 0; j--) if (m[j]) lo = j;
        if (lo == L) return;
        ok = (sz != 2'd3);
        base = a[lo] - (a[lo] % region);
        used = '0;
        for (int j = 0; j < L; j++) begin
            if (!m[j]) continue;
            if (!rel) begin
                if (a[j] != base + j * es) ok = 0;
            end else begin
                off = a[j] - base;
                if (a[j] < base || off >= region || (off % es) != 0) ok = 0;
                else if (used[off / es]) ok = 0;
                else used[off / es] = 1'b1;
            end
        end
        if (ok) begin
            it.addr = base; it.len = 9'(region); it.burst = 1'b1; it.lane = 4'd0;
            exp_q.push_back(it); tag_q.push_back(tag);
        end else begin
            for (int j = 0; j < L; j++) begin
                if (!m[j]) continue;
                it.addr = a[j]; it.len = (sz == 2'd3) ? 9'd0 : 9'(es);
                it.burst = 1'b0; it.lane = 4'(j);
                exp_q.push_back(it); tag_q.push_back(tag);
            end
        end
    endtask

    task automatic send(input logic [L-1:0] m, input logic [1:0] sz,
                        input logic rel, input string tag);
        while (!in_ready) @(negedge clk);
        for (int j = 0; j < L; j++) in_addr[j*AW +: AW] = a[j];
        in_mask = m; in_size = sz; in_relaxed = rel; in_valid = 1'b1;
        predict(m, sz, rel, tag);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || !in_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic fill_seq(input logic [AW-1:0] b, input logic [1:0] sz);
        for (int j = 0; j < L; j++) a[j] = b + (j << (2 + sz));
    endtask

    // monitor and scoreboard
    logic hold_v = 1'b0;
    item_t hold_it;
    always @(negedge clk) begin
        item_t got, want;
        string tg;
        cyc++;
        out_ready = (cyc % 5) != 2 && (cyc % 7) != 3;
        if (rst_n) begin
            got = '{addr: out_addr, len: out_len, burst: out_burst, lane: out_lane};
            if (hold_v) begin
                check(out_valid && got == hold_it, "R10", "held output",
                      {32'd0, got.addr}, {32'd0, hold_it.addr});
            end
            if (out_valid) begin
                check(!in_ready, "R10", "in_ready while busy", 64'(in_ready), 64'd0);
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected transaction", {23'd0, got}, 64'd0);
                end else begin
                    want = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    check(got == want, tg, "transaction", {23'd0, got}, {23'd0, want});
                end
            end
            hold_v = out_valid && !out_ready;
            hold_it = got;
        end
    end

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R11", "in_ready after reset", 64'(in_ready), 64'd1);
        check(out_valid == 1'b0, "R11", "out_valid after reset", 64'(out_valid), 64'd0);

        // R1 R2: aligned identity bursts at every supported size
        fill_seq(32'h1000, 2'd0); send(16'hFFFF, 2'd0, 1'b0, "R1_R2");
        fill_seq(32'h2000, 2'd1); send(16'hFFFF, 2'd1, 1'b0, "R1_R2");
        fill_seq(32'h3000, 2'd2); send(16'hFFFF, 2'd2, 1'b0, "R1_R2");
        drain();

        // R3: misaligned start in strict mode
        fill_seq(32'h1020, 2'd0); send(16'hFFFF, 2'd0, 1'b0, "R3");
        drain();

        // R4: inactive lanes hold junk
        fill_seq(32'h4000, 2'd1);
        a[1] = 32'hDEAD_BEE0; a[6] = 32'h0000_0003; a[15] = 32'h7777_0000;
        send(16'h7FBD, 2'd1, 1'b0, "R4");
        drain();

        // R5: permuted lanes, strict then relaxed
        for (int j = 0; j < L; j++) a[j] = 32'h5000 + (((j * 5 + 3) % 16) << 2);
        send(16'hFFFF, 2'd0, 1'b0, "R5");
        send(16'hFFFF, 2'd0, 1'b1, "R5");
        // relaxed with a lane outside the region
        a[9] = 32'h5040;
        send(16'hFFFF, 2'd0, 1'b1, "R5");
        drain();

        // R6: duplicate element in relaxed mode
        for (int j = 0; j < L; j++) a[j] = 32'h6000 + (((j * 3 + 1) % 16) << 3);
        a[7] = a[3];
        send(16'h00FF, 2'd1, 1'b1, "R6");
        drain();

        // R7: unsupported size
        fill_seq(32'h8000, 2'd0); send(16'h0013, 2'd3, 1'b0, "R7");
        drain();

        // R8: sparse misaligned serialization
        fill_seq(32'h9008, 2'd2); send(16'h8421, 2'd2, 1'b0, "R8");
        drain();

        // R9: empty mask
        fill_seq(32'h1234, 2'd0); send(16'h0000, 2'd0, 1'b0, "R9");
        check(in_ready == 1'b1, "R9", "in_ready after empty", 64'(in_ready), 64'd1);
        check(out_valid == 1'b0, "R9", "out_valid after empty", 64'(out_valid), 64'd0);
        fill_seq(32'hA000, 2'd0); send(16'h0001, 2'd0, 1'b0, "R9");
        drain();

        check(exp_q.size() == 0, "R8", "scoreboard empty", 64'(exp_q.size()), 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule